// File: doc/BRIEF.md
# Streaming Byte ALU with Carry Chaining

This block is the arithmetic stage of a blitter datapath. It accepts a stream of byte pairs (sources A and B) and emits one result byte per accepted pair, with no data-dependent decisions. The operation is chosen from a small set: addition, subtraction, 8x8 multiplication (low or high product byte), bitwise AND/OR/XOR, and shifts of source A that borrow bits from the byte accepted just before.

A single byte-wide adder keeps its carry between beats. The carry is re-seeded at every operand boundary, and the boundary spacing is programmable as 1, 2, 4 or 8 bytes. Multi-byte operands therefore stream least significant byte first and are added or subtracted as 16-, 32- or 64-bit quantities. Shifts work over ascending byte order only: each result byte combines the current byte with the byte held from the previous beat.

Both sides are valid/ready streams behind one output register. A stalled output keeps its byte, and it also keeps the held carry and the held previous byte. The configuration inputs are sampled on each accepted beat and are meant to stay constant across a run.

Top module: `stream_byte_alu`

## Requirements
- R1: While reset is held and right after it, `res_valid` is 0 and `src_ready` is 1.
- R2: A beat is taken when `src_valid` and `src_ready` are both 1, and `src_ready` equals `!res_valid || res_ready`. The result of a taken beat appears on `res_data` with `res_valid` 1 in the next cycle. It stays unchanged until `res_ready` is 1.
- R3: With `op_sel` = 0 (add), the result is the low byte of A + B + carry-in. The carry-in is 0 on the first byte of an operand and is the kept carry-out otherwise.
- R4: With `op_sel` = 1 (subtract), the result is the low byte of A + ~B + carry-in. The carry-in is 1 on the first byte of an operand and is the kept carry-out (not-borrow) otherwise.
- R5: `grp_code` sets the operand length in bytes: 0 gives 1, 1 gives 2, 2 gives 4 and 3 gives 8. A beat with `src_first` = 1 always starts a new operand and a new run.
- R6: With `op_sel` = 2, the result is the low byte of A*B, or the high byte when `mul_hi` = 1.
- R7: `op_sel` values 3, 4 and 5 give A AND B, A OR B and A XOR B.
- R8: With `op_sel` = 6 (shift left), the result is bits [15:8] of ({A, P} << `shamt`). P is the A byte of the previous taken beat, or 0 when `src_first` = 1.
- R9: With `op_sel` = 7 (shift right), the result is bits [7:0] of ({A, P} >> `shamt`), with P defined as in R8.
- R10: A stall (`res_valid` = 1 and `res_ready` = 0) loses neither the kept carry nor the held previous byte. A chain resumes correctly after any number of stall cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_sel | input | 3 | Operation select (0 add, 1 sub, 2 mul, 3 and, 4 or, 5 xor, 6 shl, 7 shr) |
| mul_hi | input | 1 | Multiply returns the high product byte |
| grp_code | input | 2 | Operand length code (1, 2, 4 or 8 bytes) |
| shamt | input | 3 | Shift distance in bits, 0 to 7 |
| src_valid | input | 1 | Source pair valid |
| src_ready | output | 1 | Source pair accepted |
| src_first | input | 1 | Beat begins a new run |
| src_a | input | 8 | Source A byte |
| src_b | input | 8 | Source B byte |
| res_valid | output | 1 | Result byte valid |
| res_ready | input | 1 | Downstream takes the result |
| res_data | output | 8 | Result byte |

## Verification
Two things can happen in the same cycle: a stall on the result side, and a beat whose output depends on state carried from earlier beats (a carry in the middle of an operand, or a held byte during a shift). If that state advanced or reset while the stall was in force, the wrong value would show up later. The bench drives `src_valid` and `res_ready` randomly and independently under every operation and every operand length, so stalls land in the middle of carry chains and shift runs. Directed all-ones operands force a carry to ripple through every byte of a 64-bit word. A behavioural model, updated only on the taken beats, predicts each byte, and every result leaving the block is compared with that prediction.

// File: rtl/stream_byte_alu.sv
module stream_byte_alu #(
  parameter int DW = 8,
  parameter int GW = 2,
  parameter int SW = $clog2(DW)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [2:0]    op_sel,
  input  logic          mul_hi,
  input  logic [GW-1:0] grp_code,
  input  logic [SW-1:0] shamt,
  input  logic          src_valid,
  output logic          src_ready,
  input  logic          src_first,
  input  logic [DW-1:0] src_a,
  input  logic [DW-1:0] src_b,
  output logic          res_valid,
  input  logic          res_ready,
  output logic [DW-1:0] res_data
);
  localparam int CW = (1 << GW) - 1;

  logic          carry_q;
  logic [CW-1:0] pos_q;
  logic [DW-1:0] prev_q;

  logic take;
  assign src_ready = !res_valid || res_ready;
  assign take      = src_valid && src_ready;

  // operand boundary tracking (R5)
  logic [CW-1:0] pos_eff;
  logic [CW:0]   last_pos;
  logic          grp_start, grp_end;
  assign pos_eff   = src_first ? '0 : pos_q;
  assign grp_start = (pos_eff == '0);
  assign last_pos  = ({{CW{1'b0}}, 1'b1} << grp_code) - 1'b1;
  assign grp_end   = ({1'b0, pos_eff} == last_pos);

  // chained adder (R3, R4)
  logic          is_add, is_sub, cin;
  logic [DW-1:0] b_opnd;
  logic [DW:0]   sum;
  assign is_add = (op_sel == 3'd0);
  assign is_sub = (op_sel == 3'd1);
  assign cin    = grp_start ? is_sub : carry_q;
  assign b_opnd = is_sub ? ~src_b : src_b;
  assign sum    = {1'b0, src_a} + {1'b0, b_opnd} + {{DW{1'b0}}, cin};

  // multiplier (R6)
  logic [2*DW-1:0] prod;
  assign prod = src_a * src_b;

  // funnel shifter over held byte (R8, R9)
  logic [DW-1:0]   prev_eff;
  logic [2*DW-1:0] pair, pair_l, pair_r;
  assign prev_eff = src_first ? '0 : prev_q;
  assign pair     = {src_a, prev_eff};
  assign pair_l   = pair << shamt;
  assign pair_r   = pair >> shamt;

  logic [DW-1:0] result;
  always_comb begin
    case (op_sel)
      3'd0, 3'd1: result = sum[DW-1:0];
      3'd2:       result = mul_hi ? prod[2*DW-1:DW] : prod[DW-1:0];
      3'd3:       result = src_a & src_b;
      3'd4:       result = src_a | src_b;
      3'd5:       result = src_a ^ src_b;
      3'd6:       result = pair_l[2*DW-1:DW];
      default:    result = pair_r[DW-1:0];
    endcase
  end

  // state moves only on a taken beat (R10)
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_data  <= '0;
      carry_q   <= 1'b0;
      pos_q     <= '0;
      prev_q    <= '0;
    end else if (take) begin
      res_valid <= 1'b1;
      res_data  <= result;
      prev_q    <= src_a;
      pos_q     <= grp_end ? '0 : pos_eff + 1'b1;
      if (is_add || is_sub) carry_q <= sum[DW];
    end else if (res_ready) begin
      res_valid <= 1'b0;
    end
  end
endmodule

module stream_byte_alu_chk #(
  parameter int DW = 8,
  parameter int GW = 2,
  parameter int SW = $clog2(DW)
) (
  input logic          clk,
  input logic          rst_n,
  input logic [2:0]    op_sel,
  input logic          mul_hi,
  input logic [GW-1:0] grp_code,
  input logic [SW-1:0] shamt,
  input logic          src_valid,
  input logic          src_ready,
  input logic          src_first,
  input logic [DW-1:0] src_a,
  input logic [DW-1:0] src_b,
  input logic          res_valid,
  input logic          res_ready,
  input logic [DW-1:0] res_data
);
  logic [DW-1:0] exp_add, exp_and, exp_mlo;
  assign exp_add = src_a + src_b;
  assign exp_and = src_a & src_b;
  assign exp_mlo = src_a * src_b;

  // R2
  hold_on_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |=> res_valid && $stable(res_data));
  // R2
  no_take_on_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |-> !src_ready);
  // R2
  take_gives_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    src_valid && src_ready |=> res_valid);
  // R3
  add_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    src_valid && src_ready && op_sel == 3'd0 && grp_code == '0 |=> res_data == $past(exp_add));
  // R7
  and_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
    src_valid && src_ready && op_sel == 3'd3 |=> res_data == $past(exp_and));
  // R6
  mul_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    src_valid && src_ready && op_sel == 3'd2 && !mul_hi |=> res_data == $past(exp_mlo));
  // R1
  always_ff @(posedge clk) if (!rst_n) reset_idle_chk: assert (src_ready);
endmodule

bind stream_byte_alu stream_byte_alu_chk #(.DW(DW), .GW(GW), .SW(SW)) chk_i (.*);

// File: tb/stream_byte_alu_tb.sv
module stream_byte_alu_tb_top;
  logic       clk = 0, rst_n = 0;
  logic [2:0] op_sel = 0;
  logic       mul_hi = 0;
  logic [1:0] grp_code = 0;
  logic [2:0] shamt = 0;
  logic       src_valid = 0, src_first = 0, res_ready = 0;
  logic [7:0] src_a = 0, src_b = 0;
  logic       src_ready, res_valid;
  logic [7:0] res_data;

  stream_byte_alu dut_i (.*);

  always #10 clk = ~clk;

  int n_cmp = 0, n_bad = 0;
  int m_carry = 0, m_pos = 0, m_prev = 0;
  int exp_q[$];
  string tag_q[$];
  int c_op = 0, c_hi = 0, c_grp = 0, c_sh = 0;
  bit done = 0;

  function automatic string tag_of(int op, int grp);
    case (op)
      0: return (grp > 0) ? "R3/R5/R10" : "R3";
      1: return (grp > 0) ? "R4/R5/R10" : "R4";
      2: return "R6";
      3, 4, 5: return "R7";
      6: return "R8/R10";
      default: return "R9/R10";
    endcase
  endfunction

  task automatic model_take();
    int a = src_a, b = src_b, pe, pv, e, s, cin, v;
    pe = src_first ? 0 : m_pos;
    pv = src_first ? 0 : m_prev;
    case (op_sel)
      0, 1: begin
        if (op_sel == 0) begin cin = (pe == 0) ? 0 : m_carry; s = a + b + cin; end
        else begin cin = (pe == 0) ? 1 : m_carry; s = a + (255 - b) + cin; end
        e = s % 256; m_carry = s / 256;
      end
      2: begin s = a * b; e = mul_hi ? s / 256 : s % 256; end
      3: e = a & b;
      4: e = a | b;
      5: e = a ^ b;
      6: begin v = (a * 256 + pv) << shamt; e = (v >> 8) % 256; end
      default: begin v = (a * 256 + pv) >> shamt; e = v % 256; end
    endcase
    m_pos = (pe + 1 == (1 << grp_code)) ? 0 : pe + 1;
    m_prev = a;
    exp_q.push_back(e);
    tag_q.push_back(tag_of(op_sel, grp_code));
  endtask

  task automatic observe();
    if (src_valid && src_ready) model_take();
    if (res_valid && res_ready) begin
      n_cmp++;
      if (exp_q.size() == 0) begin
        n_bad++;
        $display("FAIL R2: unexpected result actual=%0h expected=none", res_data);
      end else begin
        int e = exp_q.pop_front();
        string t = tag_q.pop_front();
        if (res_data !== 8'(e)) begin
          n_bad++;
          $display("FAIL %s: actual=%0h expected=%0h", t, res_data, e);
        end
      end
    end
  endtask

  task automatic send(int a, int b, bit first, int vpct, int rpct);
    do begin
      @(negedge clk);
      op_sel = 3'(c_op); mul_hi = c_hi[0]; grp_code = 2'(c_grp); shamt = 3'(c_sh);
      src_valid = ($urandom_range(99) < vpct);
      src_a = 8'(a); src_b = 8'(b); src_first = first;
      res_ready = ($urandom_range(99) < rpct);
      #1;
      observe();
    end while (!(src_valid && src_ready));
  endtask

  task automatic drain();
    while (exp_q.size() > 0 || res_valid) begin
      @(negedge clk);
      src_valid = 0; res_ready = ($urandom_range(99) < 60);
      #1;
      observe();
    end
  endtask

  task automatic run(int op, int hi, int grp, int sh, int n, int pat, int vpct, int rpct);
    c_op = op; c_hi = hi; c_grp = grp; c_sh = sh;
    for (int i = 0; i < n; i++) begin
      int a, b;
      if (pat == 1) begin a = 255; b = (i % (1 << grp) == 0) ? 1 : 0; end
      else if (pat == 2) begin a = 0; b = (i % (1 << grp) == 0) ? 1 : 0; end
      else begin a = $urandom_range(255); b = $urandom_range(255); end
      send(a, b, i == 0, vpct, rpct);
    end
    drain();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    n_cmp++;
    if (res_valid !== 1'b0 || src_ready !== 1'b1) begin
      n_bad++;
      $display("FAIL R1: actual valid=%0b ready=%0b expected valid=0 ready=1", res_valid, src_ready);
    end
    rst_n = 1;
    @(negedge clk);
    n_cmp++;
    if (res_valid !== 1'b0 || src_ready !== 1'b1) begin
      n_bad++;
      $display("FAIL R1: after release actual valid=%0b ready=%0b expected valid=0 ready=1", res_valid, src_ready);
    end
    // R3/R4/R5 directed ripple: all-ones + 1, zero - 1 across every length
    for (int g = 0; g < 4; g++) begin
      run(0, 0, g, 0, 16, 1, 100, 100);
      run(1, 0, g, 0, 16, 2, 100, 100);
      run(0, 0, g, 0, 16, 1, 50, 30);
    end
    // all ops, all lengths, random stalls (R2, R6..R10)
    for (int op = 0; op < 8; op++)
      for (int g = 0; g < 4; g++)
        for (int k = 0; k < 2; k++)
          run(op, k, g, $urandom_range(7), 40, 0, 70, 60);
    // R8/R9 every shift distance, heavy back-pressure
    for (int s = 0; s < 8; s++) begin
      run(6, 0, 0, s, 24, 0, 90, 25);
      run(7, 0, 0, s, 24, 0, 90, 25);
    end
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule